// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial protocol engine of a small 256-byte non-volatile store. The engine hands it a starting word address and then pushes write-data bytes one at a time. The bytes collect in a page buffer. The pointer advances only inside the current page. When the engine signals the end of the transaction, the block replays the buffered bytes into the storage array during a timed commit. A busy flag stays high for the full commit time so that the engine can refuse further traffic.

The upper half of the address space can never be written. It holds a fixed identification block: a maker code, a device code and a four-byte serial number given as a parameter. A read port returns the live contents of the lower half and the fixed contents of the upper half. While the supply-low input is active, no array write takes place. The page size (16 or 8 bytes) and the commit length in clock cycles are parameters.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy and arr_we are 0, cur_addr is 00h, and every lower-half location reads 00h.
- R2: A cycle with addr_load high and busy low loads addr_in into cur_addr and opens a transaction. Each accepted push adds 1 to only the low log2(PAGE_BYTES) bits of cur_addr, so the page bits stay fixed and the page end wraps to the page start.
- R3: When more bytes arrive than fit in a page, a later byte that lands on the same page location replaces the earlier one. The array receives only the last value for that location.
- R4: No array write happens before stop. In commit cycle i (i = 0 is the first cycle with busy high), arr_we pulses for page index i only if that location received a byte, with arr_waddr = page base + i. Locations that received no byte keep their old data.
- R5: An accepted stop with buffered data raises busy in the next cycle, and busy stays high for exactly COMMIT_CYCLES cycles. While busy is high, addr_load, push and stop have no effect.
- R6: A stop with no buffered byte leaves busy low, causes no array write, and leaves cur_addr at the loaded address.
- R7: arr_we never asserts for an address with bit 7 set (80h–FFh). A commit to that range still runs for the full busy time.
- R8: A read of FAh returns 29h, FBh returns 41h, FCh..FFh return SERIAL_NUM with the most significant byte at FCh, and any other upper-half address returns FFh.
- R9: arr_we is low in every cycle with supply_low high. A location skipped this way keeps its old data.
- R10: rd_data is a combinational read of rd_addr. In the lower half it shows the last committed byte.
- R11: A push with no open transaction (before any addr_load, or after a stop) is ignored and cur_addr does not change. Priority within one cycle is addr_load, then push, then stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load starting word address and open a transaction |
| addr_in | input | 8 | Starting word address |
| push | input | 1 | Write-data byte strobe |
| push_data | input | 8 | Write-data byte |
| stop | input | 1 | End of transaction / commit request |
| supply_low | input | 1 | Supply below write threshold; blocks array writes |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (array or fixed identification) |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit in progress |
| cur_addr | output | 8 | Current word pointer |

## Verification
The bench builds the block with an 8-byte page, a 12-cycle commit and a serial number of C0FFEE42h. The short page lets a ten-byte burst wrap and overwrite within one transaction. The short commit brings the whole busy window, and the traffic refused during it, into a few dozen cycles. A full sweep of the read port then covers every fixed upper-half byte against the parameterised serial number.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam logic [7:0]  MFG_CODE = 8'h29;
  localparam logic [7:0]  DEV_CODE = 8'h41;
  localparam logic [7:0]  BLANK    = 8'hFF;

  // Advance only the low idxw bits; the page bits stay put.
  function automatic logic [7:0] page_step(input logic [7:0] a, input int unsigned idxw);
    logic [7:0] m;
    m = 8'((9'd1 << idxw) - 9'd1);
    return (a & ~m) | ((a + 8'd1) & m);
  endfunction

  // Fixed content of the protected half.
  function automatic logic [7:0] factory_byte(input logic [7:0] a, input logic [31:0] sn);
    case (a)
      8'hFA:   return MFG_CODE;
      8'hFB:   return DEV_CODE;
      8'hFC:   return sn[31:24];
      8'hFD:   return sn[23:16];
      8'hFE:   return sn[15:8];
      8'hFF:   return sn[7:0];
      default: return BLANK;
    endcase
  endfunction
endpackage

// File: rtl/pgw_page_buffer.sv
module pgw_page_buffer #(
  parameter int unsigned PAGE_BYTES = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            take_load,
  input  logic [7:0]                      load_addr,
  input  logic                            take_push,
  input  logic [7:0]                      push_data,
  input  logic [$clog2(PAGE_BYTES)-1:0]   sel_idx,
  output logic [7:0]                      cur_addr,
  output logic [7:0]                      sel_data,
  output logic                            sel_valid,
  output logic                            any_valid
);
  import pgw_pkg::*;
  localparam int unsigned IDXW = $clog2(PAGE_BYTES);

  logic [7:0]            ptr_q;
  logic [PAGE_BYTES-1:0] vmask;
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [IDXW-1:0]       wr_idx;

  assign wr_idx = ptr_q[IDXW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (take_load) ptr_q <= load_addr;
    else if (take_push) ptr_q <= page_step(ptr_q, IDXW);
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [7:0] d_q;
    logic       v_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else if (take_load) begin
        v_q <= 1'b0;
      end else if (take_push && wr_idx == IDXW'(g)) begin
        d_q <= push_data;
        v_q <= 1'b1;
      end
    end
    assign slot_q[g] = d_q;
    assign vmask[g]  = v_q;
  end

  assign cur_addr  = ptr_q;
  assign sel_data  = slot_q[sel_idx];
  assign sel_valid = vmask[sel_idx];
  assign any_valid = |vmask;

  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    take_push |=> cur_addr[7:IDXW] == $past(cur_addr[7:IDXW]));
  a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_load && !take_push) |=> $stable(cur_addr));
  a_r4_pushed_valid: assert property (@(posedge clk) disable iff (!rst_n)
    take_push |=> any_valid);
endmodule

// File: rtl/pgw_commit_seq.sv
module pgw_commit_seq #(
  parameter int unsigned PAGE_BYTES    = 16,
  parameter int unsigned COMMIT_CYCLES = 625000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [7-$clog2(PAGE_BYTES):0]   start_page,
  input  logic                            slot_valid,
  input  logic                            supply_low,
  output logic                            busy,
  output logic [$clog2(PAGE_BYTES)-1:0]   step_idx,
  output logic                            we,
  output logic [7:0]                      waddr
);
  localparam int unsigned IDXW = $clog2(PAGE_BYTES);
  localparam int unsigned CW   = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(COMMIT_CYCLES - 1);
  localparam logic [CW-1:0] SPAN = CW'(PAGE_BYTES);

  logic [CW-1:0]     cnt_q;
  logic              busy_q;
  logic [7-IDXW:0]   page_q;
  logic              in_window;
  logic              protected_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      page_q <= start_page;
    end
  end

  assign in_window      = cnt_q < SPAN;
  assign protected_page = page_q[7-IDXW];
  assign step_idx       = cnt_q[IDXW-1:0];
  assign busy           = busy_q;
  assign we             = busy_q && in_window && slot_valid && !protected_page && !supply_low;
  assign waddr          = {page_q, step_idx};

  a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt_q <= LAST);
  a_r5_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == LAST) |=> !busy);
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != LAST) |=> busy);
  a_r5_rise_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/pgw_store.sv
module pgw_store #(
  parameter logic [31:0] SERIAL_NUM = 32'h12345678
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  import pgw_pkg::*;
  localparam int unsigned HALF = 128;

  logic [7:0] mem_q [HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HALF; i++) mem_q[i] <= '0;
    end else if (we && !waddr[7]) begin
      mem_q[waddr[6:0]] <= wdata;
    end
  end

  assign rd_data = rd_addr[7] ? factory_byte(rd_addr, SERIAL_NUM) : mem_q[rd_addr[6:0]];

  a_r7_store_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !waddr[7]);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int unsigned PAGE_BYTES    = 16,
  parameter int unsigned COMMIT_CYCLES = 625000,
  parameter logic [31:0] SERIAL_NUM    = 32'h12345678
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_load,
  input  logic [7:0] addr_in,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       stop,
  input  logic       supply_low,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       arr_we,
  output logic [7:0] arr_waddr,
  output logic [7:0] arr_wdata,
  output logic       busy,
  output logic [7:0] cur_addr
);
  localparam int unsigned IDXW = $clog2(PAGE_BYTES);

  logic            open_q;
  logic            take_load, take_push, take_stop, commit_start;
  logic            any_valid, sel_valid;
  logic [7:0]      sel_data;
  logic [IDXW-1:0] step_idx;

  assign take_load    = addr_load && !busy;
  assign take_push    = push && open_q && !busy && !addr_load;
  assign take_stop    = stop && open_q && !busy && !addr_load && !push;
  assign commit_start = take_stop && any_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (take_load) open_q <= 1'b1;
    else if (take_stop) open_q <= 1'b0;
  end

  pgw_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_load (take_load),
    .load_addr (addr_in),
    .take_push (take_push),
    .push_data (push_data),
    .sel_idx   (step_idx),
    .cur_addr  (cur_addr),
    .sel_data  (sel_data),
    .sel_valid (sel_valid),
    .any_valid (any_valid)
  );

  pgw_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (commit_start),
    .start_page (cur_addr[7:IDXW]),
    .slot_valid (sel_valid),
    .supply_low (supply_low),
    .busy       (busy),
    .step_idx   (step_idx),
    .we         (arr_we),
    .waddr      (arr_waddr)
  );

  assign arr_wdata = sel_data;

  pgw_store #(.SERIAL_NUM(SERIAL_NUM)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (arr_we),
    .waddr   (arr_waddr),
    .wdata   (arr_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  a_r7_no_upper_write: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !arr_waddr[7]);
  a_r9_no_write_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !arr_we);
  a_r4_write_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  a_r6_empty_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (take_stop && !any_valid) |=> !busy);
  a_r5_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> busy);
endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
  localparam int P  = 8;
  localparam int CC = 12;
  localparam logic [31:0] SN = 32'hC0FFEE42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 0, push = 0, stop = 0, supply_low = 0;
  logic [7:0] addr_in = 0, push_data = 0, rd_addr = 0;
  logic [7:0] rd_data, arr_waddr, arr_wdata, cur_addr;
  logic arr_we, busy;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  page_commit_ctrl #(.PAGE_BYTES(P), .COMMIT_CYCLES(CC), .SERIAL_NUM(SN)) uut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .push(push), .push_data(push_data), .stop(stop), .supply_low(supply_low),
    .rd_addr(rd_addr), .rd_data(rd_data), .arr_we(arr_we), .arr_waddr(arr_waddr),
    .arr_wdata(arr_wdata), .busy(busy), .cur_addr(cur_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fixed_val(input int a);
    if (a >= 'hFC) return int'((SN >> (8 * (3 - (a - 'hFC)))) & 32'hFF);
    if (a == 'hFA) return 'h29;
    if (a == 'hFB) return 'h41;
    return 'hFF;
  endfunction

  // Behavioural reference model
  int  m_mem [256];
  int  m_buf [P];
  bit  m_val [P];
  int  m_ptr, m_cnt, m_base;
  bit  m_busy, m_open;

  function automatic bit exp_we();
    return m_busy && m_cnt < P && m_val[m_cnt] && m_base < 128 && !supply_low;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      foreach (m_buf[i]) begin m_buf[i] = 0; m_val[i] = 0; end
      m_ptr = 0; m_cnt = 0; m_base = 0; m_busy = 0; m_open = 0;
    end else if (m_busy) begin
      if (exp_we()) m_mem[m_base + m_cnt] = m_buf[m_cnt];
      if (m_cnt == CC - 1) m_busy = 0;
      else m_cnt++;
    end else if (addr_load) begin
      m_ptr = addr_in; m_open = 1;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (push && m_open) begin
      m_buf[m_ptr % P] = push_data;
      m_val[m_ptr % P] = 1;
      m_ptr = (m_ptr / P) * P + ((m_ptr % P) + 1) % P;
    end else if (stop && m_open) begin
      bit any;
      any = 0;
      foreach (m_val[i]) any |= m_val[i];
      m_open = 0;
      if (any) begin m_busy = 1; m_cnt = 0; m_base = (m_ptr / P) * P; end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R5 busy", busy, m_busy);
      chk("R4 R7 R9 arr_we", arr_we, exp_we());
      if (exp_we()) begin
        chk("R4 arr_waddr", arr_waddr, m_base + m_cnt);
        chk("R3 arr_wdata", arr_wdata, m_buf[m_cnt]);
      end
      chk("R2 cur_addr", cur_addr, m_ptr);
      chk("R10 R8 rd_data", rd_data, (rd_addr < 128) ? m_mem[rd_addr] : fixed_val(rd_addr));
    end
  end

  task automatic load(input int a);
    addr_load = 1; addr_in = 8'(a); @(negedge clk); addr_load = 0;
  endtask
  task automatic send(input int d);
    push = 1; push_data = 8'(d); @(negedge clk); push = 0;
  endtask
  task automatic end_txn();
    stop = 1; @(negedge clk); stop = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic peek(input string req, input int a, input int exp);
    rd_addr = 8'(a); #1; chk(req, rd_data, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 arr_we", arr_we, 0);
    chk("R1 cur_addr", cur_addr, 0);
    peek("R1 mem", 8'h05, 0);
    rst_n = 1;
    @(negedge clk);

    // R11 push with nothing open
    send(8'h77);
    chk("R11 ptr unchanged", cur_addr, 0);

    // Fill page 20h fully, then a partial write into the same page (R4 mask)
    load(8'h20);
    for (int i = 0; i < P; i++) send(8'hA0 + i);
    chk("R2 wrap to page start", cur_addr, 8'h20);
    end_txn();
    chk("R5 busy raised", busy, 1);
    wait_idle();
    load(8'h25);
    send(8'h11); send(8'h12);
    chk("R2 low bits step", cur_addr, 8'h27);
    peek("R4 no write before stop", 8'h25, 8'hA5);
    end_txn();
    wait_idle();
    peek("R4 unreceived kept", 8'h24, 8'hA4);
    peek("R4 received written", 8'h26, 8'h12);

    // R3 wrap overwrite: 10 bytes from 16h in an 8-byte page
    load(8'h16);
    for (int i = 0; i < 10; i++) send(8'h30 + i);
    chk("R2 page bits fixed", cur_addr, 8'h10);
    end_txn();
    // R5: traffic during busy is refused
    load(8'h55); send(8'hEE); end_txn();
    chk("R5 load ignored", cur_addr, 8'h10);
    wait_idle();
    peek("R3 overwrite", 8'h16, 8'h38);
    peek("R3 overwrite b", 8'h17, 8'h39);
    peek("R3 wrapped", 8'h10, 8'h32);

    // R6 empty stop
    load(8'h40); end_txn();
    chk("R6 no busy", busy, 0);
    chk("R6 ptr kept", cur_addr, 8'h40);
    send(8'h99);
    chk("R11 push after stop", cur_addr, 8'h40);

    // R7 protected range
    load(8'hF8);
    for (int i = 0; i < 4; i++) send(8'h5A);
    end_txn();
    chk("R7 busy runs", busy, 1);
    wait_idle();
    peek("R7 FAh kept", 8'hFA, 8'h29);
    peek("R8 FCh msb", 8'hFC, 8'hC0);
    peek("R8 FFh lsb", 8'hFF, 8'h42);

    // R9 supply low blocks the write
    load(8'h60); send(8'hBE); send(8'hEF);
    supply_low = 1;
    end_txn();
    wait_idle();
    supply_low = 0;
    peek("R9 kept", 8'h60, 0);
    peek("R9 kept b", 8'h61, 0);

    // R9 partial: supply low drops mid-commit
    load(8'h68); send(8'h01); send(8'h02); send(8'h03);
    end_txn();
    supply_low = 1; @(negedge clk); supply_low = 0;
    wait_idle();
    peek("R9 skipped slot", 8'h68, 0);
    peek("R9 later slot", 8'h69, 8'h02);

    // R8 R10 full read sweep (compared per cycle against the model)
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a); @(negedge clk);
    end
    peek("R8 FBh", 8'hFB, 8'h41);
    peek("R8 blank", 8'h90, 8'hFF);
    finish_run();
  end
endmodule